// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the single-cycle entry into an exception handler for a small 32-bit RISC core. When the core presents a request with a 3-bit cause code, the block does three things. It saves the current program counter into the return-address register that belongs to the exception's class. It updates the interrupt-enable state. It drives a redirect strobe that carries the handler vector for the program counter.

Causes fall into two classes. Ordinary exceptions are instruction bus error, data bus error, divide-by-zero, external interrupt and system call. Debug exceptions are breakpoint and watchpoint. Each class has its own return-address register and its own saved-enable bit. A debug-remap input moves every vector onto the debug base instead of the normal base. A cause code with no handler is not redirected; it is reported on an error strobe.

The enable state (global enable, ordinary saved-enable, debug saved-enable) lives inside the block. It is exposed on outputs and can be loaded through a write port used by the core's control-register path.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the global enable, both saved-enable bits, and every strobe and data output.
- R2: A request with cause 2 (instruction bus error), 4 (data bus error), 5 (divide-by-zero), 6 (interrupt) or 7 (system call) is ordinary. It raises `ea_we` with `ea_data` equal to the request PC. `ba_we` stays low.
- R3: On an ordinary request taken while the global enable is 1, the ordinary saved-enable becomes 1 and the global enable becomes 0.
- R4: On any exception request taken while the global enable is 0, the saved-enable bit of that class keeps its previous value, whether 0 or 1.
- R5: A request with cause 1 (breakpoint) or 3 (watchpoint) is debug. It raises `ba_we` with `ba_data` equal to the request PC. The debug saved-enable is ORed with the global enable, the global enable is cleared, and the ordinary saved-enable is unchanged.
- R6: With `dbg_remap` low, every accepted cause redirects with `pc_we` high. `pc_data` is bits 31:8 of `eba`, then the 3-bit cause in bits 7:5, then zero in bits 4:0. The low 8 bits of the base are ignored.
- R7: With `dbg_remap` high, the vector of every accepted cause uses `deba` in place of `eba`, formed in the same way.
- R8: Cause 0 has no handler. It raises `bad_cause` for one cycle with no `pc_we`, `ea_we` or `ba_we`, and leaves the enable state unchanged.
- R9: When `en_wr` is high and no request is present, the enable state loads `en_wr_data`: bit 0 is the global enable, bit 1 the ordinary saved-enable, bit 2 the debug saved-enable. If a request arrives in the same cycle, the write is dropped.
- R10: All effects of a request appear on the outputs in the cycle after the edge that samples it, and last exactly one cycle. A data output reads zero in any cycle where its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present this cycle |
| req_cause | input | 3 | Cause code of the request |
| req_pc | input | 32 | Program counter at the faulting point |
| eba | input | 32 | Normal exception base address |
| deba | input | 32 | Debug exception base address |
| dbg_remap | input | 1 | Route all vectors to the debug base |
| en_wr | input | 1 | Load the enable state |
| en_wr_data | input | 3 | New enable state {debug saved, ordinary saved, global} |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Ordinary saved-enable |
| bie_o | output | 1 | Debug saved-enable |
| ea_we | output | 1 | Write strobe for the ordinary return address |
| ea_data | output | 32 | Ordinary return address value |
| ba_we | output | 1 | Write strobe for the debug return address |
| ba_data | output | 32 | Debug return address value |
| pc_we | output | 1 | Program counter redirect strobe |
| pc_data | output | 32 | Handler vector |
| bad_cause | output | 1 | Unrecognised cause reported |

## Verification
The hardest case to reach is the retention rule for a saved-enable bit. It can only be seen when an exception is taken with the global enable already cleared and the saved bit preset to a known value. The stimulus first loads chosen enable states through the write port. It then fires chains of back-to-back ordinary and debug requests, so that the second request of each pair always meets a cleared global enable. This is done with the saved bit preset to both 0 and 1. A write that collides with a request and requests with cause 0 are also driven, to show that the enable state is left alone.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RESET = 3'd0,
    CAUSE_BKPT  = 3'd1,
    CAUSE_IBUS  = 3'd2,
    CAUSE_WATCH = 3'd3,
    CAUSE_DBUS  = 3'd4,
    CAUSE_DIVZ  = 3'd5,
    CAUSE_IRQ   = 3'd6,
    CAUSE_SCALL = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ORD  = 2'd1,
    CLS_DBG  = 2'd2,
    CLS_BAD  = 2'd3
  } exc_class_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic               valid,
  input  logic [CAUSE_W-1:0] cause,
  output exc_class_e         cls
);
  always_comb begin
    cls = CLS_NONE;
    if (valid) begin
      case (cause_e'(cause))
        CAUSE_IBUS, CAUSE_DBUS, CAUSE_DIVZ, CAUSE_IRQ, CAUSE_SCALL: cls = CLS_ORD;
        CAUSE_BKPT, CAUSE_WATCH:                                     cls = CLS_DBG;
        default:                                                     cls = CLS_BAD;
      endcase
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_SHIFT = 5
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic               remap,
  input  logic [XLEN-1:0]    eba,
  input  logic [XLEN-1:0]    deba,
  output logic [XLEN-1:0]    vec
);
  localparam int LOW_W = CAUSE_W + VEC_SHIFT;

  logic [XLEN-LOW_W-1:0] base_hi;

  always_comb begin
    base_hi = remap ? deba[XLEN-1:LOW_W] : eba[XLEN-1:LOW_W];
    vec     = {base_hi, cause, {VEC_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/exc_enable_state.sv
module exc_enable_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       take_ord,
  input  logic       take_dbg,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic       ie,
  output logic       eie,
  output logic       bie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie  <= 1'b0;
      eie <= 1'b0;
      bie <= 1'b0;
    end else if (take_ord) begin
      eie <= eie | ie;
      ie  <= 1'b0;
    end else if (take_dbg) begin
      bie <= bie | ie;
      ie  <= 1'b0;
    end else if (wr_en) begin
      ie  <= wr_data[0];
      eie <= wr_data[1];
      bie <= wr_data[2];
    end
  end

  p_ord_save_r3: assert property (@(posedge clk) disable iff (rst)
    (take_ord && ie) |=> (eie && !ie));
  p_ord_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (take_ord && !ie) |=> $stable(eie));
  p_dbg_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (take_dbg && !ie) |=> $stable(bie));
  p_dbg_side_r5: assert property (@(posedge clk) disable iff (rst)
    take_dbg |=> (!ie && $stable(eie)));
  p_wr_load_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !take_ord && !take_dbg) |=> ({bie, eie, ie} == $past(wr_data)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [XLEN-1:0]    req_pc,
  input  logic [XLEN-1:0]    eba,
  input  logic [XLEN-1:0]    deba,
  input  logic               dbg_remap,
  input  logic               en_wr,
  input  logic [2:0]         en_wr_data,
  output logic               ie_o,
  output logic               eie_o,
  output logic               bie_o,
  output logic               ea_we,
  output logic [XLEN-1:0]    ea_data,
  output logic               ba_we,
  output logic [XLEN-1:0]    ba_data,
  output logic               pc_we,
  output logic [XLEN-1:0]    pc_data,
  output logic               bad_cause
);
  localparam int LOW_W = CAUSE_W + VEC_SHIFT;

  exc_class_e         cls;
  logic               take_ord, take_dbg, take_bad;
  logic [XLEN-1:0]    vec;

  exc_classify u_cls (
    .valid (req_valid),
    .cause (req_cause),
    .cls   (cls)
  );

  exc_vector #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .cause (req_cause),
    .remap (dbg_remap),
    .eba   (eba),
    .deba  (deba),
    .vec   (vec)
  );

  assign take_ord = (cls == CLS_ORD);
  assign take_dbg = (cls == CLS_DBG);
  assign take_bad = (cls == CLS_BAD);

  exc_enable_state u_en (
    .clk      (clk),
    .rst      (rst),
    .take_ord (take_ord),
    .take_dbg (take_dbg),
    .wr_en    (en_wr && !req_valid),
    .wr_data  (en_wr_data),
    .ie       (ie_o),
    .eie      (eie_o),
    .bie      (bie_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_we     <= 1'b0;
      ea_data   <= '0;
      ba_we     <= 1'b0;
      ba_data   <= '0;
      pc_we     <= 1'b0;
      pc_data   <= '0;
      bad_cause <= 1'b0;
    end else begin
      ea_we     <= take_ord;
      ea_data   <= take_ord ? req_pc : '0;
      ba_we     <= take_dbg;
      ba_data   <= take_dbg ? req_pc : '0;
      pc_we     <= take_ord || take_dbg;
      pc_data   <= (take_ord || take_dbg) ? vec : '0;
      bad_cause <= take_bad;
    end
  end

  p_one_kind_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ea_we, ba_we, bad_cause}));
  p_ord_ea_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_cause == 3'd2 || req_cause >= 3'd4))
      |=> (ea_we && !ba_we && ea_data == $past(req_pc)));
  p_dbg_ba_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_cause == 3'd1 || req_cause == 3'd3))
      |=> (ba_we && ba_data == $past(req_pc)));
  p_vec_align_r6: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (pc_data[VEC_SHIFT-1:0] == '0));
  p_remap_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dbg_remap && req_cause != 3'd0)
      |=> (pc_data[XLEN-1:LOW_W] == $past(deba[XLEN-1:LOW_W])));
  p_bad_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cause == 3'd0)
      |=> (bad_cause && !pc_we && $stable({ie_o, eie_o, bie_o})));
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cause = '0;
  logic [31:0] req_pc = '0, eba = '0, deba = '0;
  logic        dbg_remap = 1'b0, en_wr = 1'b0;
  logic [2:0]  en_wr_data = '0;
  logic        ie_o, eie_o, bie_o, ea_we, ba_we, pc_we, bad_cause;
  logic [31:0] ea_data, ba_data, pc_data;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cause(req_cause),
    .req_pc(req_pc), .eba(eba), .deba(deba), .dbg_remap(dbg_remap),
    .en_wr(en_wr), .en_wr_data(en_wr_data), .ie_o(ie_o), .eie_o(eie_o),
    .bie_o(bie_o), .ea_we(ea_we), .ea_data(ea_data), .ba_we(ba_we),
    .ba_data(ba_data), .pc_we(pc_we), .pc_data(pc_data), .bad_cause(bad_cause)
  );

  typedef struct packed {
    logic        ea_we;
    logic [31:0] ea_data;
    logic        ba_we;
    logic [31:0] ba_data;
    logic        pc_we;
    logic [31:0] pc_data;
    logic        bad;
    logic        ie, eie, bie;
  } obs_t;

  obs_t  sb_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  logic  m_ie = 0, m_eie = 0, m_bie = 0;

  function automatic obs_t sample();
    obs_t o;
    o = '{ea_we, ea_data, ba_we, ba_data, pc_we, pc_data, bad_cause, ie_o, eie_o, bie_o};
    return o;
  endfunction

  // monitor: compares each cycle's outputs against the queued expectation
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      obs_t  e, a;
      string t;
      e = sb_q.pop_front();
      t = tag_q.pop_front();
      a = sample();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the predicted outcome
  task automatic drive(input logic v, input logic [2:0] c, input logic [31:0] pc,
                       input logic [31:0] b0, input logic [31:0] b1, input logic rm,
                       input logic w, input logic [2:0] wd, input string tag);
    obs_t        e;
    logic [31:0] base;
    @(negedge clk);
    req_valid = v; req_cause = c; req_pc = pc; eba = b0; deba = b1;
    dbg_remap = rm; en_wr = w; en_wr_data = wd;
    e = '0;
    base = rm ? b1 : b0;
    if (v) begin
      if (c == 3'd0) begin
        e.bad = 1'b1;
      end else if (c == 3'd1 || c == 3'd3) begin
        e.ba_we = 1'b1; e.ba_data = pc;
        e.pc_we = 1'b1; e.pc_data = {base[31:8], c, 5'b0};
        m_bie = m_bie | m_ie; m_ie = 1'b0;
      end else begin
        e.ea_we = 1'b1; e.ea_data = pc;
        e.pc_we = 1'b1; e.pc_data = {base[31:8], c, 5'b0};
        m_eie = m_eie | m_ie; m_ie = 1'b0;
      end
    end else if (w) begin
      m_ie = wd[0]; m_eie = wd[1]; m_bie = wd[2];
    end
    e.ie = m_ie; e.eie = m_eie; e.bie = m_bie;
    sb_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0, tag);
  endtask

  task automatic wr(input logic [2:0] wd, input string tag);
    drive(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, wd, tag);
  endtask

  task automatic check_reset(input string tag);
    obs_t a;
    a = sample();
    checks++;
    if (a !== obs_t'(0)) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, obs_t'(0));
    end
  endtask

  task automatic drain();
    idle("R10 idle after burst");
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1 reset state");
    rst = 1'b0;
    idle("R1 idle after reset");

    // R3 ordinary entry with enable set
    wr(3'b001, "R9 load ie");
    drive(1, 3'd2, 32'h1000_0040, 32'hABCD_12FF, 32'h5555_0000, 0, 0, 0, "R2 R3 R6 ibus");
    // R4 retention of eie=1 with ie already clear
    drive(1, 3'd6, 32'h1000_0044, 32'hABCD_12FF, 32'h5555_0000, 0, 0, 0, "R4 eie kept 1");
    wr(3'b000, "R9 clear all");
    drive(1, 3'd4, 32'h2000_0000, 32'h0000_0100, 32'h0, 0, 0, 0, "R4 eie kept 0");
    // R5 debug entries
    wr(3'b011, "R9 ie+eie");
    drive(1, 3'd1, 32'h3000_0010, 32'h8000_0000, 32'hC000_00AA, 0, 0, 0, "R5 R6 bkpt");
    drive(1, 3'd3, 32'h3000_0014, 32'h8000_0000, 32'hC000_00AA, 0, 0, 0, "R4 R5 bie kept 1");
    wr(3'b000, "R9 clear all");
    drive(1, 3'd3, 32'h3000_0018, 32'h8000_0000, 32'hC000_00AA, 0, 0, 0, "R4 bie kept 0");
    // R7 remap
    wr(3'b001, "R9 load ie");
    drive(1, 3'd5, 32'h4000_0000, 32'h1111_11FF, 32'h2222_22FF, 1, 0, 0, "R7 divz remap");
    drive(1, 3'd1, 32'h4000_0004, 32'h1111_11FF, 32'h2222_22FF, 1, 0, 0, "R7 bkpt remap");
    // R8 bad cause with enable set and concurrent write
    wr(3'b001, "R9 load ie");
    drive(1, 3'd0, 32'h5000_0000, 32'h1111_1100, 32'h2222_2200, 0, 1, 3'b110, "R8 R9 bad cause");
    idle("R8 enables unchanged");
    // R9 write colliding with an accepted request
    drive(1, 3'd7, 32'h6000_0000, 32'h7777_7700, 32'h0, 0, 1, 3'b111, "R9 write dropped");
    // every cause under both bases
    for (int rm = 0; rm < 2; rm++) begin
      for (int c = 0; c < 8; c++) begin
        wr(3'(c), "R9 preset");
        drive(1, 3'(c), 32'h7000_0000 + 32'(c * 4), 32'h0F0F_0F3C + 32'(c),
              32'hF0F0_F0C3, 1'(rm), 0, 0, rm ? "R7 sweep" : "R6 sweep");
        idle("R10 single pulse");
      end
    end
    drain();

    // R1 reset from a non-zero state
    wr(3'b111, "R9 load all");
    drain();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check_reset("R1 reset after activity");
    rst = 1'b0;
    m_ie = 0; m_eie = 0; m_bie = 0;
    idle("R1 stays cleared");
    drain();
    finish_run();
  end
endmodule